// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block is a small, fully associative cache of address translations. A 32-bit virtual address is split into a 20-bit virtual page number and a 12-bit page offset. The page number and the current process ID are compared against every stored entry at once. On a hit, the block returns the physical address: the stored physical page number joined with the unchanged offset. It also returns the entry's permission bits and dirty bit. On a miss, it raises a miss flag, and a separate walker must then supply the translation.

Every entry carries the ID of the process that owns it. Changing the current process ID therefore leaves all entries in place, and the buffer needs a full invalidate only when process IDs are reused. New translations arrive through a refill port. Refill replaces an entry that already holds the same process/page pair. If there is no such entry, it fills the lowest-numbered free entry. If every entry is in use, it replaces the entry selected by a round-robin pointer. Lookup is combinational. Refill and invalidate take effect on the next rising clock edge.

Top module: `pid_tlb`

## Requirements
- R1: During a hit, `lk_paddr` equals {stored physical page number, `lk_vaddr[11:0]`}. For example, a mapping from page 0xFC519 to 0x00152 turns 0xFC51908B into 0x0015208B.
- R2: An entry hits only when both its page number and its process ID equal the request. The same page number can be held for two processes at once, each with its own physical page.
- R3: While `lk_req` is high, exactly one of `lk_hit` and `lk_miss` is high, in the same cycle as the request. While `lk_req` is low, both flags are low.
- R4: On a hit, `lk_perm` and `lk_dirty` return the stored values. The permission encoding is bit 0 = writable, bit 1 = readable, bit 2 = executable. `lk_fault` is high when a hit has `lk_write` high and stored bit 0 clear. It is low in every other case.
- R5: Changing `cur_pid` removes no entry. A translation is found again when its process ID comes back.
- R6: A high `inv_all` at a rising edge clears every entry, so every lookup after that edge misses.
- R7: When `fill_en` and `inv_all` are both high at the same edge, the invalidate wins and the refilled translation is not kept.
- R8: A refill with no matching pair writes the lowest-numbered invalid entry, if one exists.
- R9: A refill with no matching pair and no free entry replaces the entry at the round-robin pointer, and the pointer then advances, wrapping after the last entry. Reset sets the pointer to entry 0. Invalidate and other refills leave it unchanged.
- R10: A refill whose process/page pair is already stored overwrites that entry, so no other entry is disturbed and duplicates never form.
- R11: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pid | input | PID_W | Process ID of the current context |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_fault | output | 1 | Store to a non-writable page |
| lk_paddr | output | PPN_W+PG_W | Physical address |
| lk_perm | output | 3 | Permission bits of the matching entry |
| lk_dirty | output | 1 | Dirty bit of the matching entry |
| fill_en | input | 1 | Write a translation |
| fill_pid | input | PID_W | Process ID of the new translation |
| fill_vpn | input | VA_W-PG_W | Virtual page number of the new translation |
| fill_ppn | input | PPN_W | Physical page number of the new translation |
| fill_perm | input | 3 | Permission bits of the new translation |
| fill_dirty | input | 1 | Dirty bit of the new translation |
| inv_all | input | 1 | Invalidate every entry |

## Verification
A wrong valid bit or wrong tag appears at the ports in the same cycle as the next lookup of the affected page. The symptoms are an unexpected miss, a stale physical page, or a hit for the wrong process. A wrong victim choice is only visible later: the mapping that should have survived misses, or the one that should have been evicted still hits. For that reason, after every refill in the full state, the bench looks up every mapping that is still live as well as the one that should be gone. The round-robin pointer is also hidden, so its value is inferred from which entry the next forced replacement removes, including across an invalidate and across a duplicate refill.

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int ENTRIES = 32,
  parameter int PID_W   = 8,
  parameter int VA_W    = 32,
  parameter int PG_W    = 12,
  parameter int PPN_W   = 20,
  localparam int VPN_W  = VA_W - PG_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PID_W-1:0]       cur_pid,
  input  logic                   lk_req,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic                   lk_write,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_fault,
  output logic [PPN_W+PG_W-1:0]  lk_paddr,
  output logic [2:0]             lk_perm,
  output logic                   lk_dirty,
  input  logic                   fill_en,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [2:0]             fill_perm,
  input  logic                   fill_dirty,
  input  logic                   inv_all
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PID_W-1:0]   pid_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [ENTRIES-1:0] dirty_q;
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] hit_vec, dup_vec;
  logic [PPN_W-1:0]   hit_ppn;
  logic [2:0]         hit_perm;
  logic               hit_dirty;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid_q[i] && vpn_q[i] == lk_vaddr[VA_W-1:PG_W] && pid_q[i] == cur_pid;
    assign dup_vec[i] = valid_q[i] && vpn_q[i] == fill_vpn && pid_q[i] == fill_pid;
  end

  always_comb begin
    hit_ppn   = '0;
    hit_perm  = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn   |= {PPN_W{hit_vec[i]}} & ppn_q[i];
      hit_perm  |= {3{hit_vec[i]}} & perm_q[i];
      hit_dirty |= hit_vec[i] & dirty_q[i];
    end
  end

  assign lk_hit   = lk_req && |hit_vec;
  assign lk_miss  = lk_req && !(|hit_vec);
  assign lk_fault = lk_hit && lk_write && !hit_perm[0];
  assign lk_paddr = {hit_ppn, lk_vaddr[PG_W-1:0]};
  assign lk_perm  = hit_perm;
  assign lk_dirty = hit_dirty;

  logic [IDX_W-1:0] dup_idx, free_idx, victim;
  logic             free_any, use_rr;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i]) dup_idx = IDX_W'(i);
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
    use_rr = !(|dup_vec) && !free_any;
    victim = (|dup_vec) ? dup_idx : (free_any ? free_idx : rr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[victim] <= 1'b1;
      if (use_rr) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fill_en && !inv_all) begin
      vpn_q[victim]   <= fill_vpn;
      pid_q[victim]   <= fill_pid;
      ppn_q[victim]   <= fill_ppn;
      perm_q[victim]  <= fill_perm;
      dirty_q[victim] <= fill_dirty;
    end
  end

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss) && ((lk_hit || lk_miss) == lk_req));
  p_fault_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_hit && lk_write && !lk_perm[0]));
  p_no_dup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_inv_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));
  p_inv_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && fill_en) |=> !lk_hit);
  p_pid_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_en && !inv_all) |=> $stable(valid_q));
  p_fill_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all) |=> (valid_q != '0));

endmodule

// File: tb/sim_pid_tlb.sv
module sim_pid_tlb;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [7:0] cur_pid = 0;
  logic lk_req = 0, lk_write = 0;
  logic [31:0] lk_vaddr = 0;
  logic lk_hit, lk_miss, lk_fault, lk_dirty;
  logic [31:0] lk_paddr;
  logic [2:0] lk_perm;
  logic fill_en = 0, fill_dirty = 0, inv_all = 0;
  logic [7:0] fill_pid = 0;
  logic [19:0] fill_vpn = 0, fill_ppn = 0;
  logic [2:0] fill_perm = 0;
  int total = 0, bad = 0;
  bit done = 0;

  pid_tlb #(.ENTRIES(N)) u0 (.*);

  always #10 clk = ~clk;

  task automatic fill(input [7:0] p, input [19:0] v, input [19:0] pp,
                      input [2:0] pm, input d, input inv);
    @(negedge clk);
    fill_en = 1; fill_pid = p; fill_vpn = v; fill_ppn = pp;
    fill_perm = pm; fill_dirty = d; inv_all = inv;
    @(negedge clk);
    fill_en = 0; inv_all = 0;
  endtask

  task automatic invalidate();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  task automatic look(input string tag, input [7:0] p, input [31:0] va, input wr,
                      input eh, input [19:0] eppn, input [2:0] eperm,
                      input ed, input ef);
    logic [31:0] ea;
    cur_pid = p; lk_vaddr = va; lk_write = wr; lk_req = 1;
    #1;
    ea = {eppn, va[11:0]};
    total++;
    if (lk_hit !== eh || lk_miss !== !eh) begin
      bad++;
      $display("FAIL %s va=%h pid=%0d hit/miss act=%b%b exp=%b%b", tag, va, p, lk_hit, lk_miss, eh, !eh);
    end else if (eh && (lk_paddr !== ea || lk_perm !== eperm || lk_dirty !== ed || lk_fault !== ef)) begin
      bad++;
      $display("FAIL %s va=%h act pa=%h perm=%b d=%b f=%b exp pa=%h perm=%b d=%b f=%b",
               tag, va, lk_paddr, lk_perm, lk_dirty, lk_fault, ea, eperm, ed, ef);
    end else if (!eh && lk_fault !== 1'b0) begin
      bad++;
      $display("FAIL %s fault on miss act=%b exp=0", tag, lk_fault);
    end
    lk_req = 0; lk_write = 0;
  endtask

  function automatic [19:0] pg(input int k);
    return 20'h00100 + 20'(k) * 20'h00011;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int p = 0; p < 4; p++)
      look("R11 reset empty", 8'(p), 32'hFC51908B + 32'(p) * 32'h1000, 0, 0, 0, 0, 0, 0);
    total++;
    lk_req = 0; #1;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      bad++; $display("FAIL R3 idle flags act=%b%b exp=00", lk_hit, lk_miss);
    end

    fill(1, 20'hFC519, 20'h00152, 3'b011, 0, 0);
    look("R1 example", 1, 32'hFC51908B, 0, 1, 20'h00152, 3'b011, 0, 0);
    fill(2, 20'hFC519, 20'h00777, 3'b010, 1, 0);
    look("R2 pid1", 1, 32'hFC519000, 0, 1, 20'h00152, 3'b011, 0, 0);
    look("R2 pid2", 2, 32'hFC519FFF, 0, 1, 20'h00777, 3'b010, 1, 0);
    look("R2 pid3 miss", 3, 32'hFC519123, 0, 0, 0, 0, 0, 0);
    look("R4 fault", 2, 32'hFC519010, 1, 1, 20'h00777, 3'b010, 1, 1);
    look("R4 no fault", 1, 32'hFC519010, 1, 1, 20'h00152, 3'b011, 0, 0);
    look("R5 back to pid1", 1, 32'hFC519004, 0, 1, 20'h00152, 3'b011, 0, 0);
    look("R3 other page miss", 1, 32'hFC51A004, 0, 0, 0, 0, 0, 0);

    fill(1, 20'h00010, 20'h00AAA, 3'b111, 1, 0);
    fill(1, 20'h00020, 20'h00BBB, 3'b001, 0, 0);
    for (int o = 0; o < 4096; o += 91) begin
      look("R1 sweep A", 1, {20'hFC519, 12'(o)}, 0, 1, 20'h00152, 3'b011, 0, 0);
      look("R1 sweep B", 2, {20'hFC519, 12'(o)}, 0, 1, 20'h00777, 3'b010, 1, 0);
      look("R1 sweep C", 1, {20'h00010, 12'(o)}, 1, 1, 20'h00AAA, 3'b111, 1, 0);
      look("R1 sweep D", 1, {20'h00020, 12'(o)}, 1, 1, 20'h00BBB, 3'b001, 0, 0);
    end

    fill(1, 20'h00030, 20'h00CCC, 3'b011, 0, 0);
    look("R9 A evicted", 1, 32'hFC519000, 0, 0, 0, 0, 0, 0);
    look("R9 E present", 1, 32'h00030ABC, 0, 1, 20'h00CCC, 3'b011, 0, 0);
    look("R9 B kept", 2, 32'hFC519000, 0, 1, 20'h00777, 3'b010, 1, 0);
    fill(1, 20'h00040, 20'h00EEE, 3'b011, 0, 0);
    look("R9 B evicted", 2, 32'hFC519000, 0, 0, 0, 0, 0, 0);

    fill(1, 20'h00010, 20'h00DDD, 3'b000, 0, 0);
    look("R10 C updated", 1, 32'h00010321, 1, 1, 20'h00DDD, 3'b000, 0, 1);
    look("R10 D kept", 1, 32'h00020321, 0, 1, 20'h00BBB, 3'b001, 0, 0);
    look("R10 E kept", 1, 32'h00030321, 0, 1, 20'h00CCC, 3'b011, 0, 0);
    look("R10 F kept", 1, 32'h00040321, 0, 1, 20'h00EEE, 3'b011, 0, 0);
    fill(1, 20'h00050, 20'h00FFF, 3'b011, 0, 0);
    look("R9 ptr skip dup, C evicted", 1, 32'h00010000, 0, 0, 0, 0, 0, 0);
    look("R9 D still kept", 1, 32'h00020000, 0, 1, 20'h00BBB, 3'b001, 0, 0);

    invalidate();
    for (int k = 0; k < 6; k++)
      look("R6 all gone", 1, {20'h00010 + 20'(k) * 20'h10, 12'h0}, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < N; k++) fill(3, pg(k), pg(k) + 20'h50000, 3'b011, 0, 0);
    for (int k = 0; k < N; k++)
      look("R8 free first", 3, {pg(k), 12'h5A5}, 0, 1, pg(k) + 20'h50000, 3'b011, 0, 0);
    fill(3, pg(7), 20'h12345, 3'b011, 0, 0);
    look("R9 ptr kept over inv", 3, {pg(N - 1), 12'h0}, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < N - 1; k++)
      look("R9 others kept", 3, {pg(k), 12'h0}, 0, 1, pg(k) + 20'h50000, 3'b011, 0, 0);
    look("R9 new one", 3, {pg(7), 12'hFFF}, 0, 1, 20'h12345, 3'b011, 0, 0);

    invalidate();
    fill(4, 20'h0ABCD, 20'h0DCBA, 3'b011, 0, 1);
    look("R7 inv wins", 4, 32'h0ABCD000, 0, 0, 0, 0, 0, 0);
    fill(4, 20'h0ABCD, 20'h0DCBA, 3'b011, 0, 0);
    look("R8 fills after inv", 4, 32'h0ABCD00F, 0, 1, 20'h0DCBA, 3'b011, 0, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule